// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames from memory onto a byte stream. Software builds a ring of 8-byte descriptors in memory, each a control word followed by a pointer word. The control word names the descriptor kind in bits 31:28 and a byte count in bits 11:0. A small table whose address software programs holds the entry where the transmit queue begins. That entry is normally a jump to the real ring.

Software puts the engine in operation mode, fills in a frame descriptor and raises the start request. The engine then walks the chain. It follows jump entries, reads each frame's buffer as 32-bit little-endian words and emits the bytes one per beat. When a frame is done it writes the "empty" kind back into that descriptor, so software polling the descriptor can see it was consumed. The engine stops, and drops the start request, when it meets a descriptor that holds no work.

A later start resumes at the descriptor where the engine stopped. This matches a driver that refills descriptors in ring order.

Top module: `tdma_tx_engine`

## Requirements
- R1: Register word 0 is the mode. Writing with bit 0 set enters configuration mode, and bit 0 wins if both bits are set. Writing with only bit 1 set enters operation mode. Reset leaves the block in configuration mode. A read returns bit 1 = operation and bit 0 = configuration.
- R2: Register word 1 holds the descriptor table base address and reads back as written.
- R3: Register word 2, bit 0, is the start request. Writing 1 sets it only in operation mode; in configuration mode the write is ignored and no memory access follows. Writing 0 has no effect. The register reads back the current request.
- R4: The first start after entering operation mode fetches the descriptor at the table base address. Every later start resumes at the descriptor where the engine last stopped.
- R5: A descriptor of kind 0x7 sends its byte count of bytes from the buffer address (low two address bits ignored). Bytes go in rising address order, taken from each 32-bit word little-endian, one byte per beat. The last flag is set on the final byte only.
- R6: A kind-0x7 descriptor with a byte count of zero emits no beats but is still completed and written back.
- R7: A descriptor of kind 0x9 makes the engine continue at the address held in its pointer word.
- R8: A descriptor of kind 0x3 (empty), 0xA (end of set) or any other unlisted kind stops the engine and clears the start request. That descriptor is left unmodified in memory.
- R9: After a frame, the engine writes its control word back with bits 31:28 = 0x3 and bits 27:0 unchanged. It then continues at the descriptor 8 bytes further on.
- R10: A beat with valid high and ready low keeps valid, data and last unchanged in the next cycle.
- R11: A memory request is held, with address and direction stable, until granted. Read data is taken in the grant cycle, and a write takes place in the grant cycle.
- R12: Entering configuration mode aborts the engine. From the next cycle it issues no memory request and no beat, the start request reads 0, and the aborted descriptor is not written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request |
| mem_gnt | input | 1 | Memory grant; the access completes in this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid while granted |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream beat valid |
| tx_ready | input | 1 | Stream beat accepted |
| tx_last | output | 1 | Final byte of a frame |

## Verification
Register writes take effect at the clock edge of the write, so readbacks and the abort checks in R12 sample at the next falling edge. The start request sets at that edge, and the first memory request follows one cycle later. After that, memory grant and stream ready are random, so a frame's completion time varies from run to run. The bench therefore polls the start request with a bounded loop and checks captured bytes and descriptor memory only after the request has dropped. The abort test waits for beats, writes the mode, and samples request, valid and the start request at the very next falling edge.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  localparam logic [3:0] KIND_FRAME = 4'h7;
  localparam logic [3:0] KIND_JUMP  = 4'h9;
  localparam logic [3:0] KIND_EOS   = 4'hA;
  localparam logic [3:0] KIND_EMPTY = 4'h3;

  localparam logic [1:0] ADR_MODE  = 2'd0;
  localparam logic [1:0] ADR_BASE  = 2'd1;
  localparam logic [1:0] ADR_TXCTL = 2'd2;

  typedef enum logic [2:0] {
    WK_IDLE, WK_CTRL, WK_PTR, WK_DECODE, WK_LOAD, WK_SEND, WK_DONE
  } walk_e;
endpackage

// File: rtl/tdma_regs.sv
module tdma_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          stop_pulse,
  output logic          op_mode,
  output logic [AW-1:0] base_addr,
  output logic          start_req
);
  import tdma_pkg::*;

  logic          op_q, op_d;
  logic          start_q, start_d;
  logic [AW-1:0] base_q, base_d;
  logic          upd;

  assign upd = wr | stop_pulse;

  always_comb begin
    op_d    = op_q;
    base_d  = base_q;
    start_d = start_q & ~stop_pulse;
    if (wr) begin
      unique case (addr)
        ADR_MODE: begin
          if (wdata[0])      op_d = 1'b0;
          else if (wdata[1]) op_d = 1'b1;
        end
        ADR_BASE:  base_d = wdata[AW-1:0];
        ADR_TXCTL: if (wdata[0] && op_q) start_d = 1'b1;
        default: ;
      endcase
    end
    if (!op_d) start_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= 1'b0;
      start_q <= 1'b0;
      base_q  <= '0;
    end else if (upd) begin
      op_q    <= op_d;
      start_q <= start_d;
      base_q  <= base_d;
    end
  end

  always_comb begin
    unique case (addr)
      ADR_MODE:  rdata = {30'd0, op_q, ~op_q};
      ADR_BASE:  rdata = 32'(base_q);
      ADR_TXCTL: rdata = {31'd0, start_q};
      default:   rdata = 32'd0;
    endcase
  end

  assign op_mode   = op_q;
  assign base_addr = base_q;
  assign start_req = start_q;
endmodule

// File: rtl/tdma_lane_pick.sv
module tdma_lane_pick #(
  parameter int LANES = 4,
  localparam int SW = $clog2(LANES)
) (
  input  logic [8*LANES-1:0] word,
  input  logic [SW-1:0]      sel,
  output logic [7:0]         byte_o
);
  logic [7:0] lane [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane[i] = word[8*i +: 8];
  end

  assign byte_o = lane[sel];
endmodule

// File: rtl/tdma_walker.sv
module tdma_walker #(
  parameter int AW = 32,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_mode,
  input  logic          start_req,
  input  logic [AW-1:0] base_addr,
  output logic          stop_pulse,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          beat_valid,
  input  logic          beat_ready,
  output logic          beat_last,
  output logic [1:0]    lane,
  output logic [31:0]   word
);
  import tdma_pkg::*;

  localparam logic [AW-1:0] STEP_PTR  = AW'(4);
  localparam logic [AW-1:0] STEP_DESC = AW'(8);

  walk_e         st_q, st_d;
  logic [AW-1:0] cur_q, cur_d, ptr_q, ptr_d;
  logic [31:0]   ctrl_q, ctrl_d, word_q, word_d;
  logic [CW-1:0] bcnt_q, bcnt_d, bnext, count;
  logic          loaded_q, loaded_d, is_last;
  logic          req_i, valid_i, stop_i;

  assign count   = ctrl_q[CW-1:0];
  assign bnext   = bcnt_q + CW'(1);
  assign is_last = (bnext == count);

  always_comb begin
    st_d = st_q; cur_d = cur_q; ptr_d = ptr_q; ctrl_d = ctrl_q;
    word_d = word_q; bcnt_d = bcnt_q; loaded_d = loaded_q;
    req_i = 1'b0; valid_i = 1'b0; stop_i = 1'b0;
    mem_we = 1'b0;
    mem_addr = cur_q;
    mem_wdata = {KIND_EMPTY, ctrl_q[27:0]};
    unique case (st_q)
      WK_IDLE: if (start_req) begin
        st_d = WK_CTRL;
        if (!loaded_q) begin
          cur_d = base_addr;
          loaded_d = 1'b1;
        end
      end
      WK_CTRL: begin
        req_i = 1'b1;
        if (mem_gnt) begin ctrl_d = mem_rdata; st_d = WK_PTR; end
      end
      WK_PTR: begin
        req_i = 1'b1;
        mem_addr = cur_q + STEP_PTR;
        if (mem_gnt) begin ptr_d = mem_rdata; st_d = WK_DECODE; end
      end
      WK_DECODE: begin
        unique case (ctrl_q[31:28])
          KIND_FRAME: begin
            bcnt_d = '0;
            st_d = (count == '0) ? WK_DONE : WK_LOAD;
          end
          KIND_JUMP: begin cur_d = ptr_q; st_d = WK_CTRL; end
          default: begin stop_i = 1'b1; st_d = WK_IDLE; end
        endcase
      end
      WK_LOAD: begin
        req_i = 1'b1;
        mem_addr = {ptr_q[AW-1:2], 2'b00} + AW'({bcnt_q[CW-1:2], 2'b00});
        if (mem_gnt) begin word_d = mem_rdata; st_d = WK_SEND; end
      end
      WK_SEND: begin
        valid_i = 1'b1;
        if (beat_ready) begin
          bcnt_d = bnext;
          if (is_last)                  st_d = WK_DONE;
          else if (bcnt_q[1:0] == 2'd3) st_d = WK_LOAD;
        end
      end
      WK_DONE: begin
        req_i = 1'b1;
        mem_we = 1'b1;
        if (mem_gnt) begin cur_d = cur_q + STEP_DESC; st_d = WK_CTRL; end
      end
      default: st_d = WK_IDLE;
    endcase
    if (!op_mode) begin
      st_d = WK_IDLE;
      loaded_d = 1'b0;
    end
  end

  assign mem_req    = req_i & op_mode;
  assign beat_valid = valid_i & op_mode;
  assign stop_pulse = stop_i & op_mode;
  assign beat_last  = valid_i & op_mode & is_last;
  assign lane       = bcnt_q[1:0];
  assign word       = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= WK_IDLE; cur_q <= '0; ptr_q <= '0; ctrl_q <= '0;
      word_q <= '0; bcnt_q <= '0; loaded_q <= 1'b0;
    end else begin
      st_q <= st_d; cur_q <= cur_d; ptr_q <= ptr_d; ctrl_q <= ctrl_d;
      word_q <= word_d; bcnt_q <= bcnt_d; loaded_q <= loaded_d;
    end
  end
endmodule

// File: rtl/tdma_tx_engine.sv
module tdma_tx_engine #(
  parameter int AW = 32,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_last
);
  logic          op_mode, start_req, stop_pulse;
  logic [AW-1:0] base_addr;
  logic [31:0]   word;
  logic [1:0]    lane;

  tdma_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .stop_pulse(stop_pulse),
    .op_mode(op_mode), .base_addr(base_addr), .start_req(start_req)
  );

  tdma_walker #(.AW(AW), .CW(CW)) u_walk (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .start_req(start_req),
    .base_addr(base_addr), .stop_pulse(stop_pulse),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .beat_valid(tx_valid), .beat_ready(tx_ready), .beat_last(tx_last),
    .lane(lane), .word(word)
  );

  tdma_lane_pick #(.LANES(4)) u_pick (
    .word(word), .sel(lane), .byte_o(tx_data)
  );
endmodule

// File: rtl/tdma_tx_engine_chk.sv
module tdma_tx_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_mode,
  input logic          start_req,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    wb_kind,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last
);
  // R10
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid || !op_mode);

  // R10
  beat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> !op_mode || ($stable(tx_data) && $stable(tx_last)));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> !op_mode || (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R9
  wb_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> wb_kind == 4'h3);

  // R12
  quiet_in_config_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_mode |-> !mem_req && !tx_valid && !start_req);

  // R8
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_req) |-> !mem_req && !tx_valid);
endmodule

bind tdma_tx_engine tdma_tx_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .start_req(start_req),
  .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
  .mem_addr(mem_addr), .wb_kind(mem_wdata[31:28]),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
);

// File: tb/tb_tdma_tx_engine.sv
module tb_tdma_tx_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic        mem_gnt = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last;
  logic        tx_ready = 1'b0;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int idx = 0;
  logic [31:0] mem [0:255];
  logic [7:0]  cap_d [0:63];
  logic        cap_l [0:63];
  int          cap_n = 0;
  logic        cap_clr = 1'b0;

  always #2 clk = ~clk;

  tdma_tx_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last)
  );

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk)
    if (rst_n && mem_req && mem_gnt && mem_we) mem[mem_addr[9:2]] = mem_wdata;

  always @(posedge clk) begin
    if (cap_clr) cap_n <= 0;
    else if (rst_n && tx_valid && tx_ready && cap_n < 64) begin
      cap_d[cap_n] <= tx_data;
      cap_l[cap_n] <= tx_last;
      cap_n <= cap_n + 1;
    end
  end

  always @(negedge clk) begin
    mem_gnt  = ($urandom % 4) != 0;
    tx_ready = ($urandom % 4) != 0;
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] exp_byte(input int addr);
    logic [31:0] w = mem[(addr >> 2) & 255];
    return w[8*(addr % 4) +: 8];
  endfunction

  task automatic wait_idle(input string ctx);
    logic [31:0] r;
    bit done = 1'b0;
    for (int k = 0; k < 5000 && !done; k++) begin
      @(negedge clk);
      reg_read(2'd2, r);
      if (r[0] == 1'b0) done = 1'b1;
    end
    check(done, {ctx, " R8 start request never cleared"}, 32'(done), 32'd1);
    @(negedge clk);
  endtask

  task automatic clear_cap();
    @(negedge clk); cap_clr = 1'b1;
    @(negedge clk); cap_clr = 1'b0;
  endtask

  // One frame at ring slot idx; the next slot holds a stop descriptor.
  task automatic run_round(input int len, input bit use_eos, input string ctx);
    int d = 'h100 + idx * 8;
    int nxt = (idx + 1) % 3;
    int nd = 'h100 + nxt * 8;
    int buf_a = 'h200 + idx * 64;
    logic [31:0] ctrl, nword;
    int errs = 0;
    int lasts = 0;
    for (int k = 0; k < 16; k++) mem[(buf_a >> 2) + k] = $urandom;
    ctrl = {4'h7, 16'($urandom), 12'(len)};
    mem[d >> 2] = ctrl;
    mem[(d >> 2) + 1] = 32'(buf_a);
    if (use_eos) mem[nd >> 2] = {4'hA, 28'($urandom)};
    nword = mem[nd >> 2];
    clear_cap();
    reg_write(2'd2, 32'd1);
    wait_idle(ctx);
    // R5 R6: beat count equals byte count
    check(cap_n == len, {ctx, " R5 R6 beat count"}, 32'(cap_n), 32'(len));
    for (int k = 0; k < len && k < cap_n; k++) begin
      if (cap_d[k] != exp_byte(buf_a + k)) errs++;
      if (cap_l[k]) lasts++;
    end
    // R5 R10: byte order and values under random ready
    check(errs == 0, {ctx, " R5 R10 byte mismatches"}, 32'(errs), 32'd0);
    check(lasts == (len > 0 ? 1 : 0) && (len == 0 || cap_l[len-1]),
          {ctx, " R5 last flag count"}, 32'(lasts), 32'(len > 0 ? 1 : 0));
    // R9 R11: write-back of the finished descriptor
    check(mem[d >> 2] == {4'h3, ctrl[27:0]}, {ctx, " R9 R11 write-back"},
          mem[d >> 2], {4'h3, ctrl[27:0]});
    // R8: stop descriptor untouched
    check(mem[nd >> 2] == nword, {ctx, " R8 stop descriptor unchanged"}, mem[nd >> 2], nword);
    idx = nxt;
  endtask

  initial begin
    logic [31:0] r;
    bit quiet;
    void'($urandom(32'd4242));
    for (int k = 0; k < 256; k++) mem[k] = 32'd0;
    mem['h40 >> 2] = {4'h9, 28'd0}; mem[('h40 >> 2) + 1] = 32'h100;
    for (int k = 0; k < 3; k++) mem[('h100 >> 2) + 2*k] = {4'h3, 28'd0};
    mem['h118 >> 2] = {4'h9, 28'd0}; mem[('h118 >> 2) + 1] = 32'h100;

    repeat (3) @(negedge clk);
    check(!mem_req && !tx_valid, "R12 outputs idle in reset", {mem_req, tx_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    reg_read(2'd0, r); check(r == 32'h1, "R1 reset mode is configuration", r, 32'h1);
    reg_read(2'd2, r); check(r == 32'h0, "R3 reset start request", r, 32'h0);

    reg_write(2'd1, 32'h40);
    reg_read(2'd1, r); check(r == 32'h40, "R2 base readback", r, 32'h40);

    reg_write(2'd2, 32'd1);
    reg_read(2'd2, r); check(r == 32'h0, "R3 start ignored in configuration", r, 32'h0);
    quiet = 1'b1;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (mem_req) quiet = 1'b0; end
    check(quiet, "R3 no memory access in configuration", 32'(quiet), 32'd1);

    reg_write(2'd0, 32'h2);
    reg_read(2'd0, r); check(r == 32'h2, "R1 operation mode readback", r, 32'h2);
    reg_write(2'd2, 32'd0);
    reg_read(2'd2, r); check(r == 32'h0, "R3 writing zero has no effect", r, 32'h0);

    run_round(5, 1'b0, "first via table jump R7 R4");
    run_round(4, 1'b1, "resume R4 end-of-set");
    run_round(1, 1'b0, "ring wrap R7");
    run_round(0, 1'b0, "zero count R6");
    run_round(3, 1'b0, "odd length");
    run_round(8, 1'b1, "two words");
    for (int n = 0; n < 12; n++) run_round(int'($urandom % 61), n % 3 == 0, "random");

    begin
      int d = 'h100 + idx * 8;
      int cnt_before;
      logic [31:0] ctrl = {4'h7, 16'h5a5a, 12'd60};
      mem[d >> 2] = ctrl;
      mem[(d >> 2) + 1] = 32'('h200 + idx * 64);
      clear_cap();
      reg_write(2'd2, 32'd1);
      for (int k = 0; k < 2000 && cap_n < 3; k++) @(negedge clk);
      reg_write(2'd0, 32'h3);
      check(!tx_valid && !mem_req, "R12 abort quiets outputs", {tx_valid, mem_req}, 32'd0);
      reg_read(2'd2, r); check(r == 32'h0, "R12 abort clears start request", r, 32'h0);
      reg_read(2'd0, r); check(r == 32'h1, "R1 configuration wins over operation", r, 32'h1);
      cnt_before = cap_n;
      repeat (20) @(negedge clk);
      check(cap_n == cnt_before, "R12 no beats after abort", 32'(cap_n), 32'(cnt_before));
      check(mem[d >> 2] == ctrl, "R12 aborted descriptor not written back", mem[d >> 2], ctrl);
    end

    reg_write(2'd0, 32'h2);
    for (int k = 0; k < 3; k++) mem[('h100 >> 2) + 2*k] = {4'h3, 28'd0};
    idx = 0;
    run_round(9, 1'b0, "restart from base R4");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule